// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block works out which of up to 32 local interrupt controllers should receive an interrupt message. A request names an 8-bit destination, whether that destination is physical or logical, a 2-bit shorthand, the index of the sending controller and a 3-bit delivery mode with its level and trigger bits. Each controller's physical ID, 8-bit logical destination and 4-bit logical model arrive on static configuration buses. The block sets one bit in the target mask for each controller that the request addresses.

From the target mask the block derives a delivery mask. For lowest-priority delivery only one controller receives the message: the one with the lowest index among the targets. An INIT de-assert message is not delivered at all. Instead, the targets are reported on a separate mask that tells each of them to copy its physical ID into its arbitration ID. Priority arbitration between controllers and the transport of the message are handled elsewhere.

Requests enter on a valid/ready channel. The result leaves on a second valid/ready channel and is registered one cycle after acceptance. A result is held while `res_ready` is low. `req_ready` is high exactly when the output register is empty or is being drained in the same cycle, so a new request can be accepted in every cycle while the consumer keeps `res_ready` high. A request must stay stable while it waits for `req_ready`. The configuration buses are sampled on the cycle the request is accepted.

Top module: `ipi_dest_resolver`

## Requirements
- R1: With `req_shorthand`=0 and `req_logical`=0, a destination of 8'hFF targets every controller. Any other destination targets only the lowest-indexed controller whose physical ID equals it, or no controller if none matches.
- R2: With `req_shorthand`=0 and `req_logical`=1, a controller whose model is 4'hF (flat) is targeted when the AND of the destination and its logical destination is nonzero.
- R3: With `req_shorthand`=0 and `req_logical`=1, a controller whose model is 4'h0 (cluster) is targeted when bits [7:4] of the destination and of its logical destination are equal and the AND of their bits [3:0] is nonzero.
- R4: In logical mode, a controller whose model is neither 4'hF nor 4'h0 is never targeted.
- R5: The `req_shorthand` encodings are as follows. 0 uses the destination fields. 1 targets only controller `req_sender`. 2 targets all controllers. 3 targets all controllers except `req_sender`. When the shorthand is nonzero, `req_dest` and `req_logical` are ignored.
- R6: When `req_mode` is 3'b001 (lowest priority), `res_deliver` is one-hot on the lowest set bit of `res_targets`, or all zero if the targets are empty.
- R7: When `req_mode` is 3'b101 (INIT) with `req_level`=0 and `req_trigger`=1, `res_deliver` is zero and `res_arb_sync` equals `res_targets`. For every other request, `res_arb_sync` is zero, and for every mode other than 3'b001, `res_deliver` equals `res_targets`.
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both high) raises `res_valid` at that edge, with the fields computed from that request and the configuration present at the same edge.
- R9: While `res_valid` is high and `res_ready` is low, `req_ready` is low and all result outputs hold their values. `req_ready` equals `!res_valid || res_ready`. An edge with `res_ready` high and no accepted request clears `res_valid`.
- R10: While `rst_n` is low, `res_valid`, `res_targets`, `res_deliver` and `res_arb_sync` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_dest | input | 8 | Destination ID or logical destination |
| req_logical | input | 1 | 1 = logical destination, 0 = physical |
| req_shorthand | input | 2 | 0 fields, 1 self, 2 all, 3 all but self |
| req_sender | input | 5 | Index of the sending controller |
| req_mode | input | 3 | Delivery mode (3'b001 lowest priority, 3'b101 INIT) |
| req_level | input | 1 | Level bit of the message |
| req_trigger | input | 1 | Trigger bit of the message |
| cfg_phys_id | input | 256 | Physical ID of controller i at bits [8i+7:8i] |
| cfg_log_dest | input | 256 | Logical destination of controller i at bits [8i+7:8i] |
| cfg_model | input | 128 | Logical model of controller i at bits [4i+3:4i] |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_targets | output | 32 | Controllers addressed by the request |
| res_deliver | output | 32 | Controllers that receive the message |
| res_arb_sync | output | 32 | Controllers told to load arbitration ID from physical ID |

## Verification
Three situations are the hardest to reach from the ports. The first is a physical destination that matches several controllers, which happens only when the configuration repeats an ID. The second is a cluster controller whose group nibble matches but whose member bits do not overlap the destination. The third is a held result while a second request waits. The directed configuration gives two controllers the same ID and leaves another ID absent, and it lays out cluster groups whose members are single bits. The random phase draws IDs from a narrow range so that repeats are common, takes logical destinations from the configured groups, and pulls `res_ready` low at random so that results are held while requests wait.

// File: rtl/idr_pkg.sv
package idr_pkg;

  typedef enum logic [2:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWEST = 3'd1,
    DLV_SMI    = 3'd2,
    DLV_RSVD   = 3'd3,
    DLV_NMI    = 3'd4,
    DLV_INIT   = 3'd5,
    DLV_START  = 3'd6,
    DLV_EXTINT = 3'd7
  } dlv_mode_e;

  typedef enum logic [1:0] {
    SH_FIELDS = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam int MODEL_W = 4;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

endpackage

// File: rtl/idr_first_set.sv
module idr_first_set #(
  parameter int N = 32
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] first_o
);

  // Scan from the top so the lowest set index is the last write.
  always_comb begin
    first_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        first_o    = '0;
        first_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/idr_dest_match.sv
module idr_dest_match
  import idr_pkg::*;
#(
  parameter int N      = 32,
  parameter int DEST_W = 8
) (
  input  logic [DEST_W-1:0]    dest_i,
  input  logic                 logical_i,
  input  logic [N*DEST_W-1:0]  cfg_phys_id_i,
  input  logic [N*DEST_W-1:0]  cfg_log_dest_i,
  input  logic [N*MODEL_W-1:0] cfg_model_i,
  output logic [N-1:0]         addr_mask_o
);

  localparam int NIB = DEST_W / 2;

  logic [N-1:0] phys_hit;
  logic [N-1:0] log_hit;
  logic [N-1:0] phys_first;
  logic         bcast;

  for (genvar g = 0; g < N; g++) begin : g_ctrl
    logic [DEST_W-1:0]  id_w;
    logic [DEST_W-1:0]  ld_w;
    logic [MODEL_W-1:0] model_w;
    logic               flat_hit;
    logic               clu_hit;

    assign id_w    = cfg_phys_id_i[g*DEST_W +: DEST_W];
    assign ld_w    = cfg_log_dest_i[g*DEST_W +: DEST_W];
    assign model_w = cfg_model_i[g*MODEL_W +: MODEL_W];

    assign phys_hit[g] = (id_w == dest_i);
    assign flat_hit    = |(dest_i & ld_w);
    assign clu_hit     = (dest_i[DEST_W-1:NIB] == ld_w[DEST_W-1:NIB]) &&
                         (|(dest_i[NIB-1:0] & ld_w[NIB-1:0]));
    assign log_hit[g]  = (model_w == MODEL_FLAT)    ? flat_hit :
                         (model_w == MODEL_CLUSTER) ? clu_hit  : 1'b0;
  end

  // Repeated physical IDs resolve to the lowest index.
  idr_first_set #(.N(N)) u_phys_first (
    .vec_i   (phys_hit),
    .first_o (phys_first)
  );

  assign bcast = &dest_i;

  always_comb begin
    if (logical_i)  addr_mask_o = log_hit;
    else if (bcast) addr_mask_o = '1;
    else            addr_mask_o = phys_first;
  end

endmodule

// File: rtl/idr_shorthand_sel.sv
module idr_shorthand_sel
  import idr_pkg::*;
#(
  parameter int N     = 32,
  parameter int SEL_W = 5
) (
  input  logic [1:0]       shorthand_i,
  input  logic [SEL_W-1:0] sender_i,
  input  logic [N-1:0]     addr_mask_i,
  output logic [N-1:0]     targets_o
);

  logic [N-1:0] self_oh;

  assign self_oh = N'(1) << sender_i;

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_FIELDS: targets_o = addr_mask_i;
      SH_SELF:   targets_o = self_oh;
      SH_ALL:    targets_o = '1;
      SH_OTHERS: targets_o = ~self_oh;
      default:   targets_o = '0;
    endcase
  end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import idr_pkg::*;
#(
  parameter  int N      = 32,
  parameter  int DEST_W = 8,
  localparam int SEL_W  = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [DEST_W-1:0]    req_dest,
  input  logic                 req_logical,
  input  logic [1:0]           req_shorthand,
  input  logic [SEL_W-1:0]     req_sender,
  input  logic [2:0]           req_mode,
  input  logic                 req_level,
  input  logic                 req_trigger,
  input  logic [N*DEST_W-1:0]  cfg_phys_id,
  input  logic [N*DEST_W-1:0]  cfg_log_dest,
  input  logic [N*MODEL_W-1:0] cfg_model,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [N-1:0]         res_targets,
  output logic [N-1:0]         res_deliver,
  output logic [N-1:0]         res_arb_sync
);

  logic [N-1:0] addr_mask;
  logic [N-1:0] targets;
  logic [N-1:0] lowest;
  logic [N-1:0] deliver_nxt;
  logic [N-1:0] arb_nxt;
  logic         init_deassert;
  logic         accept;

  idr_dest_match #(.N(N), .DEST_W(DEST_W)) u_match (
    .dest_i         (req_dest),
    .logical_i      (req_logical),
    .cfg_phys_id_i  (cfg_phys_id),
    .cfg_log_dest_i (cfg_log_dest),
    .cfg_model_i    (cfg_model),
    .addr_mask_o    (addr_mask)
  );

  idr_shorthand_sel #(.N(N), .SEL_W(SEL_W)) u_short (
    .shorthand_i (req_shorthand),
    .sender_i    (req_sender),
    .addr_mask_i (addr_mask),
    .targets_o   (targets)
  );

  idr_first_set #(.N(N)) u_lowest (
    .vec_i   (targets),
    .first_o (lowest)
  );

  assign init_deassert = (req_mode == DLV_INIT) && !req_level && req_trigger;

  always_comb begin
    arb_nxt = '0;
    if (req_mode == DLV_LOWEST) begin
      deliver_nxt = lowest;
    end else if (init_deassert) begin
      deliver_nxt = '0;
      arb_nxt     = targets;
    end else begin
      deliver_nxt = targets;
    end
  end

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_targets  <= '0;
      res_deliver  <= '0;
      res_arb_sync <= '0;
    end else if (accept) begin
      res_valid    <= 1'b1;
      res_targets  <= targets;
      res_deliver  <= deliver_nxt;
      res_arb_sync <= arb_nxt;
    end else if (res_ready) begin
      res_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
  parameter  int N      = 32,
  parameter  int DEST_W = 8,
  localparam int SEL_W  = $clog2(N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [DEST_W-1:0] req_dest,
  input logic              req_logical,
  input logic [1:0]        req_shorthand,
  input logic [SEL_W-1:0]  req_sender,
  input logic [2:0]        req_mode,
  input logic              res_valid,
  input logic              res_ready,
  input logic [N-1:0]      res_targets,
  input logic [N-1:0]      res_deliver,
  input logic [N-1:0]      res_arb_sync
);

  logic fire;
  assign fire = req_valid && req_ready;

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_targets) &&
                                   $stable(res_deliver) && $stable(res_arb_sync)));

  // R6
  lowest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_mode == 3'b001) |=>
      ($onehot0(res_deliver) && ((res_deliver & ~res_targets) == '0)));

  // R7
  arb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_deliver & res_arb_sync) == '0));

  // R5
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_shorthand == 2'd1) |=> (res_targets == (N'(1) << $past(req_sender))));

  // R5
  all_but_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_shorthand == 2'd3) |=>
      (($countones(res_targets) == N - 1) && !res_targets[$past(req_sender)]));

  // R1
  phys_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_shorthand == 2'd0 && !req_logical && (&req_dest)) |=> (&res_targets));

  // R1
  phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_shorthand == 2'd0 && !req_logical && !(&req_dest)) |=> $onehot0(res_targets));

endmodule

bind ipi_dest_resolver idr_checker #(.N(N), .DEST_W(DEST_W)) u_idr_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_dest      (req_dest),
  .req_logical   (req_logical),
  .req_shorthand (req_shorthand),
  .req_sender    (req_sender),
  .req_mode      (req_mode),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_targets   (res_targets),
  .res_deliver   (res_deliver),
  .res_arb_sync  (res_arb_sync)
);

// File: tb/ipi_dest_resolver_test.sv
module ipi_dest_resolver_test;

  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [7:0]   req_dest = '0;
  logic         req_logical = 1'b0;
  logic [1:0]   req_shorthand = '0;
  logic [4:0]   req_sender = '0;
  logic [2:0]   req_mode = '0;
  logic         req_level = 1'b0;
  logic         req_trigger = 1'b0;
  logic [N*8-1:0] cfg_phys_id;
  logic [N*8-1:0] cfg_log_dest;
  logic [N*4-1:0] cfg_model;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [N-1:0] res_targets;
  logic [N-1:0] res_deliver;
  logic [N-1:0] res_arb_sync;

  logic [7:0] m_id    [N];
  logic [7:0] m_ld    [N];
  logic [3:0] m_model [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_phys_id[i*8 +: 8]  = m_id[i];
      cfg_log_dest[i*8 +: 8] = m_ld[i];
      cfg_model[i*4 +: 4]    = m_model[i];
    end
  end

  ipi_dest_resolver uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical),
    .req_shorthand(req_shorthand), .req_sender(req_sender),
    .req_mode(req_mode), .req_level(req_level), .req_trigger(req_trigger),
    .cfg_phys_id(cfg_phys_id), .cfg_log_dest(cfg_log_dest), .cfg_model(cfg_model),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_targets(res_targets), .res_deliver(res_deliver), .res_arb_sync(res_arb_sync)
  );

  int vectors = 0;
  int miscompares = 0;
  bit reported = 1'b0;

  // Reference state
  bit          exp_valid = 1'b0;
  logic [31:0] exp_targets = '0;
  logic [31:0] exp_deliver = '0;
  logic [31:0] exp_arb = '0;
  string       exp_tag = "R10";
  bit          accepted_last = 1'b0;

  function automatic logic [31:0] ref_targets(logic [7:0] d, logic lg, logic [1:0] sh, logic [4:0] snd);
    logic [31:0] r = '0;
    logic [31:0] me = 32'd1 << snd;
    bit found = 1'b0;
    if (sh == 2'd1)      r = me;
    else if (sh == 2'd2) r = 32'hFFFF_FFFF;
    else if (sh == 2'd3) r = 32'hFFFF_FFFF & ~me;
    else if (!lg) begin
      if (d == 8'hFF) r = 32'hFFFF_FFFF;
      else
        for (int i = 0; i < N; i++)
          if (!found && m_id[i] == d) begin r[i] = 1'b1; found = 1'b1; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m_model[i] == 4'hF && (d & m_ld[i]) != 0) r[i] = 1'b1;
        if (m_model[i] == 4'h0 && d[7:4] == m_ld[i][7:4] && (d[3:0] & m_ld[i][3:0]) != 0) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic model_step();
    bit ready_m = !exp_valid || res_ready;
    accepted_last = 1'b0;
    if (!rst_n) begin
      exp_valid = 1'b0; exp_targets = '0; exp_deliver = '0; exp_arb = '0; exp_tag = "R10";
    end else if (req_valid && ready_m) begin
      logic [31:0] t = ref_targets(req_dest, req_logical, req_shorthand, req_sender);
      accepted_last = 1'b1;
      exp_valid   = 1'b1;
      exp_targets = t;
      exp_arb     = '0;
      if (req_mode == 3'b001) begin
        exp_deliver = '0;
        for (int i = N - 1; i >= 0; i--) if (t[i]) exp_deliver = 32'd1 << i;
      end else if (req_mode == 3'b101 && !req_level && req_trigger) begin
        exp_deliver = '0;
        exp_arb     = t;
      end else begin
        exp_deliver = t;
      end
      if (req_shorthand != 2'd0) exp_tag = "R5";
      else if (req_logical)      exp_tag = "R2/R3/R4";
      else                       exp_tag = "R1";
    end else if (res_ready) begin
      exp_valid = 1'b0;
    end
  endtask

  task automatic compare();
    string vt = rst_n ? "R8" : "R10";
    vectors++;
    if (res_valid !== exp_valid) begin
      miscompares++;
      $display("FAIL %s res_valid: got %b expected %b", vt, res_valid, exp_valid);
    end
    if (res_targets !== exp_targets) begin
      miscompares++;
      $display("FAIL %s res_targets: got %h expected %h", exp_tag, res_targets, exp_targets);
    end
    if (res_deliver !== exp_deliver) begin
      miscompares++;
      $display("FAIL R6/R7 res_deliver: got %h expected %h", res_deliver, exp_deliver);
    end
    if (res_arb_sync !== exp_arb) begin
      miscompares++;
      $display("FAIL R7 res_arb_sync: got %h expected %h", res_arb_sync, exp_arb);
    end
    if (rst_n && req_ready !== (!exp_valid || res_ready)) begin
      miscompares++;
      $display("FAIL R9 req_ready: got %b expected %b", req_ready, !exp_valid || res_ready);
    end
  endtask

  task automatic set_req(logic [7:0] d, logic lg, logic [1:0] sh, logic [4:0] snd,
                         logic [2:0] md, logic lv, logic tr);
    req_valid = 1'b1; req_dest = d; req_logical = lg; req_shorthand = sh;
    req_sender = snd; req_mode = md; req_level = lv; req_trigger = tr;
  endtask

  // Directed cases: R1 broadcast/dup/miss, R2/R3 logical, R4 odd models,
  // R6 lowest priority incl. empty, R5 shorthands, R7 INIT variants.
  task automatic directed(int k);
    case (k)
      0:  set_req(8'hFF, 0, 2'd0, 5'd0,  3'b000, 1, 0);
      1:  set_req(8'h05, 0, 2'd0, 5'd0,  3'b000, 1, 0);
      2:  set_req(8'h09, 0, 2'd0, 5'd0,  3'b000, 1, 0);
      3:  set_req(8'h21, 1, 2'd0, 5'd0,  3'b000, 1, 0);
      4:  set_req(8'h30, 1, 2'd0, 5'd0,  3'b100, 1, 0);
      5:  set_req(8'hFF, 1, 2'd0, 5'd0,  3'b001, 1, 0);
      6:  set_req(8'h09, 0, 2'd0, 5'd0,  3'b001, 1, 0);
      7:  set_req(8'h22, 1, 2'd0, 5'd0,  3'b001, 1, 0);
      8:  set_req(8'h00, 0, 2'd1, 5'd7,  3'b000, 1, 0);
      9:  set_req(8'h05, 1, 2'd2, 5'd3,  3'b000, 1, 0);
      10: set_req(8'h05, 0, 2'd3, 5'd31, 3'b001, 1, 0);
      11: set_req(8'h00, 0, 2'd2, 5'd0,  3'b101, 0, 1);
      12: set_req(8'h03, 1, 2'd0, 5'd0,  3'b101, 1, 0);
      default: set_req(8'h06, 0, 2'd0, 5'd0, 3'b101, 0, 0);
    endcase
  endtask

  task automatic random_cfg();
    for (int i = 0; i < N; i++) begin
      m_id[i] = 8'($urandom_range(0, 40));
      m_ld[i] = 8'($urandom);
      case ($urandom_range(0, 3))
        0, 1: m_model[i] = 4'hF;
        2:    m_model[i] = 4'h0;
        default: m_model[i] = 4'($urandom);
      endcase
    end
  endtask

  task automatic random_req();
    int pick = $urandom_range(0, N - 1);
    logic [7:0] d;
    logic lg = 1'($urandom);
    if (!lg) d = ($urandom_range(0, 3) == 0) ? 8'hFF : m_id[pick];
    else     d = {m_ld[pick][7:4], 4'($urandom)};
    if ($urandom_range(0, 7) == 0) d = 8'($urandom);
    set_req(d, lg, ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'd0,
            5'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
    req_valid = ($urandom_range(0, 9) < 7);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    int dk = 0;
    for (int i = 0; i < N; i++) begin
      m_id[i] = 8'(i);
      if (i < 8)       begin m_ld[i] = 8'(1 << i);               m_model[i] = 4'hF; end
      else if (i < 16) begin m_ld[i] = {4'h2, 4'(1 << (i % 4))}; m_model[i] = 4'h0; end
      else if (i < 24) begin m_ld[i] = {4'h3, 4'(1 << (i % 4))}; m_model[i] = 4'h0; end
      else             begin m_ld[i] = 8'hFF;                    m_model[i] = 4'h5; end
    end
    m_id[9] = 8'h05;  // repeated ID, and ID 9 absent (R1)

    repeat (4) begin @(negedge clk); model_step(); compare(); end
    rst_n = 1'b1;

    // Directed phase, with a few back-pressure cycles (R9)
    for (int cyc = 0; cyc < 200 && dk < 14; cyc++) begin
      @(negedge clk);
      model_step();
      compare();
      if (accepted_last || !req_valid) begin
        if (accepted_last) dk++;
        if (dk < 14) directed(dk); else req_valid = 1'b0;
      end
      res_ready = (cyc % 5 != 2);
    end

    // Random phase
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      model_step();
      compare();
      if (cyc % 64 == 0 && !(req_valid && !accepted_last)) random_cfg();
      if (!(req_valid && !accepted_last)) random_req();
      res_ready = ($urandom_range(0, 9) < 6);
    end

    req_valid = 1'b0;
    res_ready = 1'b1;
    repeat (3) begin @(negedge clk); model_step(); compare(); end
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

endmodule